// File: doc/BRIEF.md
# ANSI Control and Escape Sequence Parser

This block sits between a byte-wide display data register and a character-cell display controller. Each byte written to the display is sorted into one of two kinds. A printable character is passed on with a one-cycle strobe. A terminal command is decoded into a command code with an operand. Single-byte control codes give clear screen, carriage return and line feed. Multi-byte sequences that begin with ESC and '[' carry numeric parameters and end in a final letter. The final letter 'm' sets the foreground colour.

Parameters are decimal numbers of any length and saturate at the width of the accumulator. Up to `NPARAM` of them can be given, separated by ';'. The block keeps the current foreground colour and reports it. A build option chooses how that colour is used. In one mode it is tagged onto every printed character. In the other it applies to the whole display, and printed characters carry the default colour.

Frame buffer writes, cursor storage, font lookup and video timing belong to the controller behind this block.

Top module: `ansi_seq_parser`

## Requirements
- R1: A byte 0x0C accepted outside a sequence makes `cmd_stb` high for one cycle on the next clock, with `cmd_code` = 1 (clear whole screen).
- R2: Outside a sequence, 0x0D gives `cmd_code` = 2 (carriage return to column 0) and 0x0A gives `cmd_code` = 3 (line feed, one row down), each on the next clock.
- R3: A byte in 0x20..0x7E accepted outside a sequence makes `chr_stb` high for exactly one cycle on the next clock, with `chr_byte` equal to that byte.
- R4: 0x1B followed by 0x5B opens a control sequence. No byte of an open sequence raises `chr_stb`. Only a final 'm' (0x6D) raises `cmd_stb`.
- R5: Inside a sequence, digits 0x30..0x39 build a parameter as value×10+digit. The parameter saturates at 2^PW−1 and does not wrap.
- R6: Final 'm' gives `cmd_code` = 4 (set foreground). A parameter from 30 to 37 selects colour index parameter−30. This index appears on `cmd_arg` and, from the same clock, on `colour`.
- R7: Final 'm' with a parameter of 0, or with no digits at all, restores colour `DEFAULT_FG`.
- R8: ';' starts the next parameter, up to `NPARAM`. Parameters are applied in the order given, so the last usable one wins. A value that is neither 0 nor 30..37 leaves the colour unchanged, and the command is still issued. A ';' when all `NPARAM` slots are already in use aborts the sequence.
- R9: The sequence is aborted silently and the parser returns to text mode in four cases: ESC followed by a byte other than '[', a final byte other than 'm', any byte outside 0x20..0x7E inside a sequence, or any other non-digit byte inside a sequence.
- R10: Outside a sequence, bytes below 0x20 other than 0x0A, 0x0D, 0x0C and 0x1B, and also 0x7F and above, produce no strobe. A cycle with `in_valid` low produces no strobe.
- R11: With `PER_CHAR_COLOUR` = 1, `chr_attr` equals the current colour. With 0, `chr_attr` equals `DEFAULT_FG`.
- R12: During and just after reset both strobes are low, the parser is in text mode and `colour` equals `DEFAULT_FG`.
- R13: `in_ready` is high on every cycle. One byte is taken per cycle with `in_valid` high. `cmd_stb` and `chr_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_byte` |
| in_byte | input | 8 | Character stream byte |
| in_ready | output | 1 | Always high: a byte is taken whenever `in_valid` is high |
| chr_stb | output | 1 | One-cycle printable character strobe |
| chr_byte | output | 8 | Printable character, valid with `chr_stb` |
| chr_attr | output | 3 | Colour index to store with the character |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | 3 | 1 clear, 2 carriage return, 3 line feed, 4 set foreground |
| cmd_arg | output | 3 | Colour index for code 4 |
| colour | output | 3 | Current foreground colour index |

## Verification
If the parser is stuck in the wrong mode, it shows at the ports on the clock after the very next byte. Sequence bytes then come out as characters, or a printable byte is swallowed. A fault in the parameter accumulator or its slot index stays hidden until the final 'm'. At that point it appears as a wrong `cmd_arg` and `colour`. The bench therefore ends every parameter pattern with 'm' or with a printable byte. It checks values chosen so that wrapping instead of saturating would land on a valid colour. It also checks that an aborted sequence is followed by a byte that must print.

// File: rtl/ansi_pkg.sv
package ansi_pkg;
   localparam logic [2:0] CMD_NONE  = 3'd0;
   localparam logic [2:0] CMD_CLEAR = 3'd1;
   localparam logic [2:0] CMD_CR    = 3'd2;
   localparam logic [2:0] CMD_LF    = 3'd3;
   localparam logic [2:0] CMD_SETFG = 3'd4;

   localparam logic [7:0] B_ESC   = 8'h1B;
   localparam logic [7:0] B_LBR   = 8'h5B;
   localparam logic [7:0] B_SEP   = 8'h3B;
   localparam logic [7:0] B_FIN_M = 8'h6D;

   typedef enum logic [1:0] {
      PS_TEXT = 2'd0,
      PS_ESC  = 2'd1,
      PS_CSI  = 2'd2
   } pstate_e;
endpackage

// File: rtl/ansi_byte_class.sv
module ansi_byte_class
   import ansi_pkg::*;
(
   input  logic [7:0] b,
   output logic       is_print,
   output logic       is_digit,
   output logic       is_sep,
   output logic       is_fin_m,
   output logic       is_lbr,
   output logic       is_esc,
   output logic [2:0] ctl_cmd,
   output logic [3:0] digit
);
   always_comb begin
      is_print = (b >= 8'h20) && (b <= 8'h7E);
      is_digit = (b >= 8'h30) && (b <= 8'h39);
      is_sep   = (b == B_SEP);
      is_fin_m = (b == B_FIN_M);
      is_lbr   = (b == B_LBR);
      is_esc   = (b == B_ESC);
      digit    = b[3:0];
      unique case (b)
         8'h0C:   ctl_cmd = CMD_CLEAR;
         8'h0D:   ctl_cmd = CMD_CR;
         8'h0A:   ctl_cmd = CMD_LF;
         default: ctl_cmd = CMD_NONE;
      endcase
   end
endmodule

// File: rtl/ansi_param_acc.sv
module ansi_param_acc #(
   parameter int PW     = 8,
   parameter int NPARAM = 2,
   localparam int IW    = (NPARAM > 1) ? $clog2(NPARAM) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 dig_en,
   input  logic [3:0]           digit,
   input  logic                 sep_en,
   output logic [NPARAM*PW-1:0] params,
   output logic [IW-1:0]        idx,
   output logic                 slots_full
);
   localparam int WW = PW + 4;
   localparam logic [WW-1:0] LIM = WW'((1 << PW) - 1);

   logic [IW-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         idx_q <= '0;
      else if (sep_en)
         idx_q <= idx_q + IW'(1);
   end

   for (genvar g = 0; g < NPARAM; g++) begin : g_slot
      logic [PW-1:0] val_q;
      logic [WW-1:0] nxt;
      always_comb nxt = ({4'b0, val_q} * WW'(10)) + WW'(digit);
      always_ff @(posedge clk) begin
         if (!rst_n || clr)
            val_q <= '0;
         else if (dig_en && (idx_q == IW'(g)))
            val_q <= (nxt > LIM) ? LIM[PW-1:0] : nxt[PW-1:0];
      end
      assign params[g*PW +: PW] = val_q;
   end

   assign idx        = idx_q;
   assign slots_full = (idx_q == IW'(NPARAM - 1));
endmodule

// File: rtl/ansi_colour_eval.sv
module ansi_colour_eval #(
   parameter int         PW         = 8,
   parameter int         NPARAM     = 2,
   parameter logic [2:0] DEFAULT_FG = 3'd7,
   localparam int        IW         = (NPARAM > 1) ? $clog2(NPARAM) : 1
) (
   input  logic [NPARAM*PW-1:0] params,
   input  logic [IW-1:0]        idx,
   input  logic [2:0]           cur,
   output logic [2:0]           nxt
);
   always_comb begin
      logic [PW-1:0] p;
      nxt = cur;
      for (int i = 0; i < NPARAM; i++) begin
         p = params[i*PW +: PW];
         if (IW'(i) <= idx) begin
            if (p == '0)
               nxt = DEFAULT_FG;
            else if ((p >= PW'(30)) && (p <= PW'(37)))
               nxt = 3'(p - PW'(30));
         end
      end
   end
endmodule

// File: rtl/ansi_seq_parser.sv
module ansi_seq_parser
   import ansi_pkg::*;
#(
   parameter int         PW              = 8,
   parameter int         NPARAM          = 2,
   parameter logic [2:0] DEFAULT_FG      = 3'd7,
   parameter bit         PER_CHAR_COLOUR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   output logic       in_ready,
   output logic       chr_stb,
   output logic [7:0] chr_byte,
   output logic [2:0] chr_attr,
   output logic       cmd_stb,
   output logic [2:0] cmd_code,
   output logic [2:0] cmd_arg,
   output logic [2:0] colour
);
   localparam int IW = (NPARAM > 1) ? $clog2(NPARAM) : 1;

   if (PW < 6 || PW > 16) begin : g_bad_pw
      $error("PW must hold 37 and stay below 17 bits");
   end
   if (NPARAM < 1 || NPARAM > 8) begin : g_bad_np
      $error("NPARAM must be 1 to 8");
   end

   logic       is_print, is_digit, is_sep, is_fin_m, is_lbr, is_esc;
   logic [2:0] ctl_cmd;
   logic [3:0] digit;

   ansi_byte_class u_cls (
      .b        (in_byte),
      .is_print (is_print),
      .is_digit (is_digit),
      .is_sep   (is_sep),
      .is_fin_m (is_fin_m),
      .is_lbr   (is_lbr),
      .is_esc   (is_esc),
      .ctl_cmd  (ctl_cmd),
      .digit    (digit)
   );

   logic                 acc_clr, acc_dig, acc_sep, slots_full;
   logic [NPARAM*PW-1:0] params;
   logic [IW-1:0]        idx;

   ansi_param_acc #(.PW(PW), .NPARAM(NPARAM)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (acc_clr),
      .dig_en     (acc_dig),
      .digit      (digit),
      .sep_en     (acc_sep),
      .params     (params),
      .idx        (idx),
      .slots_full (slots_full)
   );

   pstate_e    st_q, st_n;
   logic [2:0] colour_q, colour_eval;

   ansi_colour_eval #(.PW(PW), .NPARAM(NPARAM), .DEFAULT_FG(DEFAULT_FG)) u_col (
      .params (params),
      .idx    (idx),
      .cur    (colour_q),
      .nxt    (colour_eval)
   );

   logic [2:0] cmd_n;
   logic       chr_n;
   logic       col_we;

   always_comb begin
      st_n    = st_q;
      cmd_n   = CMD_NONE;
      chr_n   = 1'b0;
      col_we  = 1'b0;
      acc_clr = 1'b0;
      acc_dig = 1'b0;
      acc_sep = 1'b0;
      if (in_valid) begin
         unique case (st_q)
            PS_TEXT: begin
               if (is_esc)
                  st_n = PS_ESC;
               else if (ctl_cmd != CMD_NONE)
                  cmd_n = ctl_cmd;
               else if (is_print)
                  chr_n = 1'b1;
            end
            PS_ESC: begin
               if (is_lbr) begin
                  st_n    = PS_CSI;
                  acc_clr = 1'b1;
               end else begin
                  st_n = PS_TEXT;
               end
            end
            PS_CSI: begin
               if (is_digit) begin
                  acc_dig = 1'b1;
               end else if (is_sep) begin
                  if (slots_full)
                     st_n = PS_TEXT;
                  else
                     acc_sep = 1'b1;
               end else if (is_fin_m) begin
                  cmd_n  = CMD_SETFG;
                  col_we = 1'b1;
                  st_n   = PS_TEXT;
               end else begin
                  st_n = PS_TEXT;
               end
            end
            default: st_n = PS_TEXT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= PS_TEXT;
         colour_q <= DEFAULT_FG;
         cmd_stb  <= 1'b0;
         cmd_code <= CMD_NONE;
         cmd_arg  <= '0;
         chr_stb  <= 1'b0;
         chr_byte <= '0;
      end else begin
         st_q    <= st_n;
         cmd_stb <= (cmd_n != CMD_NONE);
         chr_stb <= chr_n;
         if (cmd_n != CMD_NONE) begin
            cmd_code <= cmd_n;
            cmd_arg  <= col_we ? colour_eval : '0;
         end
         if (col_we)
            colour_q <= colour_eval;
         if (chr_n)
            chr_byte <= in_byte;
      end
   end

   if (PER_CHAR_COLOUR) begin : g_attr_cell
      assign chr_attr = colour_q;
   end else begin : g_attr_screen
      assign chr_attr = DEFAULT_FG;
   end

   assign in_ready = 1'b1;
   assign colour   = colour_q;
endmodule

// File: rtl/ansi_seq_parser_chk.sv
module ansi_seq_parser_chk #(
   parameter logic [2:0] DEFAULT_FG = 3'd7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic [7:0] in_byte,
   input logic [1:0] st,
   input logic       chr_stb,
   input logic [7:0] chr_byte,
   input logic       cmd_stb,
   input logic [2:0] cmd_code,
   input logic [2:0] cmd_arg,
   input logic [2:0] colour
);
   a_r1_clear_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_byte == 8'h0C && st == 2'd0) |=> (cmd_stb && cmd_code == 3'd1));

   a_r2_cr_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_byte == 8'h0D && st == 2'd0) |=> (cmd_stb && cmd_code == 3'd2));

   a_r2_lf_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_byte == 8'h0A && st == 2'd0) |=> (cmd_stb && cmd_code == 3'd3));

   a_r3_chr_printable: assert property (@(posedge clk) disable iff (!rst_n)
      chr_stb |-> (chr_byte >= 8'h20 && chr_byte <= 8'h7E));

   a_r4_seq_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && st != 2'd0 && in_byte != 8'h6D) |=> (!cmd_stb && !chr_stb));

   a_r6_colour_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(colour) |-> (cmd_stb && cmd_code == 3'd4 && cmd_arg == colour));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!cmd_stb && !chr_stb));

   a_r12_reset_state: assert property (@(posedge clk)
      $rose(rst_n) |-> (!cmd_stb && !chr_stb && colour == DEFAULT_FG));

   a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_stb, chr_stb}));
endmodule

bind ansi_seq_parser ansi_seq_parser_chk #(.DEFAULT_FG(DEFAULT_FG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_byte  (in_byte),
   .st       (st_q),
   .chr_stb  (chr_stb),
   .chr_byte (chr_byte),
   .cmd_stb  (cmd_stb),
   .cmd_code (cmd_code),
   .cmd_arg  (cmd_arg),
   .colour   (colour)
);

// File: tb/sim_ansi_seq_parser.sv
`timescale 1ns/1ps
module sim_ansi_seq_parser;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_ready, chr_stb, cmd_stb;
   logic [7:0] chr_byte;
   logic [2:0] chr_attr, cmd_code, cmd_arg, colour;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ansi_seq_parser u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .chr_stb(chr_stb), .chr_byte(chr_byte),
      .chr_attr(chr_attr), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
      .cmd_arg(cmd_arg), .colour(colour)
   );

   // {byte, expect char strobe, expect cmd code (0 none), expect arg, expect colour}
   localparam int NV = 60;
   localparam logic [17:0] VEC [NV] = '{
      {8'h41,1'b1,3'd0,3'd0,3'd7}, {8'h0C,1'b0,3'd1,3'd0,3'd7},
      {8'h0D,1'b0,3'd2,3'd0,3'd7}, {8'h0A,1'b0,3'd3,3'd0,3'd7},
      {8'h01,1'b0,3'd0,3'd0,3'd7}, {8'h1B,1'b0,3'd0,3'd0,3'd7},
      {8'h5B,1'b0,3'd0,3'd0,3'd7}, {8'h33,1'b0,3'd0,3'd0,3'd7},
      {8'h33,1'b0,3'd0,3'd0,3'd7}, {8'h6D,1'b0,3'd4,3'd3,3'd3},
      {8'h78,1'b1,3'd0,3'd0,3'd3}, {8'h1B,1'b0,3'd0,3'd0,3'd3},
      {8'h5B,1'b0,3'd0,3'd0,3'd3}, {8'h6D,1'b0,3'd4,3'd7,3'd7},
      {8'h1B,1'b0,3'd0,3'd0,3'd7}, {8'h5B,1'b0,3'd0,3'd0,3'd7},
      {8'h33,1'b0,3'd0,3'd0,3'd7}, {8'h31,1'b0,3'd0,3'd0,3'd7},
      {8'h3B,1'b0,3'd0,3'd0,3'd7}, {8'h33,1'b0,3'd0,3'd0,3'd7},
      {8'h32,1'b0,3'd0,3'd0,3'd7}, {8'h6D,1'b0,3'd4,3'd2,3'd2},
      {8'h1B,1'b0,3'd0,3'd0,3'd2}, {8'h5B,1'b0,3'd0,3'd0,3'd2},
      {8'h39,1'b0,3'd0,3'd0,3'd2}, {8'h39,1'b0,3'd0,3'd0,3'd2},
      {8'h6D,1'b0,3'd4,3'd2,3'd2}, {8'h1B,1'b0,3'd0,3'd0,3'd2},
      {8'h5B,1'b0,3'd0,3'd0,3'd2}, {8'h33,1'b0,3'd0,3'd0,3'd2},
      {8'h48,1'b0,3'd0,3'd0,3'd2}, {8'h33,1'b1,3'd0,3'd0,3'd2},
      {8'h1B,1'b0,3'd0,3'd0,3'd2}, {8'h51,1'b0,3'd0,3'd0,3'd2},
      {8'h5B,1'b1,3'd0,3'd0,3'd2}, {8'h1B,1'b0,3'd0,3'd0,3'd2},
      {8'h5B,1'b0,3'd0,3'd0,3'd2}, {8'h33,1'b0,3'd0,3'd0,3'd2},
      {8'h3B,1'b0,3'd0,3'd0,3'd2}, {8'h34,1'b0,3'd0,3'd0,3'd2},
      {8'h3B,1'b0,3'd0,3'd0,3'd2}, {8'h6D,1'b1,3'd0,3'd0,3'd2},
      {8'h1B,1'b0,3'd0,3'd0,3'd2}, {8'h5B,1'b0,3'd0,3'd0,3'd2},
      {8'h33,1'b0,3'd0,3'd0,3'd2}, {8'h30,1'b0,3'd0,3'd0,3'd2},
      {8'h0D,1'b0,3'd0,3'd0,3'd2}, {8'h6D,1'b1,3'd0,3'd0,3'd2},
      {8'h1B,1'b0,3'd0,3'd0,3'd2}, {8'h5B,1'b0,3'd0,3'd0,3'd2},
      {8'h32,1'b0,3'd0,3'd0,3'd2}, {8'h38,1'b0,3'd0,3'd0,3'd2},
      {8'h36,1'b0,3'd0,3'd0,3'd2}, {8'h6D,1'b0,3'd4,3'd2,3'd2},
      {8'h1B,1'b0,3'd0,3'd0,3'd2}, {8'h5B,1'b0,3'd0,3'd0,3'd2},
      {8'h30,1'b0,3'd0,3'd0,3'd2}, {8'h6D,1'b0,3'd4,3'd7,3'd7},
      {8'h7E,1'b1,3'd0,3'd0,3'd7}, {8'h7F,1'b0,3'd0,3'd0,3'd7}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Sampled at the negedge after the accepting posedge.
   task automatic chk_out(input string req, input bit e_chr, input logic [7:0] e_byte,
                          input logic [2:0] e_code, input logic [2:0] e_arg,
                          input logic [2:0] e_col);
      chk({req, " chr_stb"}, int'(chr_stb), int'(e_chr));
      if (e_chr) begin
         chk({req, " chr_byte"}, int'(chr_byte), int'(e_byte));
         chk({req, " chr_attr R11"}, int'(chr_attr), int'(e_col));
      end
      chk({req, " cmd_stb"}, int'(cmd_stb), int'(e_code != 3'd0));
      if (e_code != 3'd0) chk({req, " cmd_code"}, int'(cmd_code), int'(e_code));
      if (e_code == 3'd4) chk({req, " cmd_arg"}, int'(cmd_arg), int'(e_arg));
      chk({req, " colour"}, int'(colour), int'(e_col));
      chk("R13 in_ready", int'(in_ready), 1);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      string tag;
      repeat (3) @(negedge clk);
      // R12: state during reset
      chk("R12 chr_stb in reset", int'(chr_stb), 0);
      chk("R12 cmd_stb in reset", int'(cmd_stb), 0);
      chk("R12 colour in reset", int'(colour), 7);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 strobes after reset", int'(chr_stb | cmd_stb), 0);

      // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
      for (int i = 0; i < NV; i++) begin
         in_valid = 1'b1;
         in_byte  = VEC[i][17:10];
         @(negedge clk);
         in_valid = 1'b0;
         case (VEC[i][8:6])
            3'd1:    tag = "R1";
            3'd2:    tag = "R2";
            3'd3:    tag = "R2";
            3'd4:    tag = "R6/R7/R8/R5";
            default: tag = VEC[i][9] ? "R3" : "R4/R9/R10";
         endcase
         chk_out($sformatf("%s vec%0d", tag, i), VEC[i][9], VEC[i][17:10],
                 VEC[i][8:6], VEC[i][5:3], VEC[i][2:0]);
      end

      // R10: byte held with in_valid low
      in_byte = 8'h0C;
      @(negedge clk);
      chk_out("R10 valid low", 1'b0, 8'h00, 3'd0, 3'd0, 3'd7);

      // R13: back-to-back bytes, one per cycle
      in_valid = 1'b1;
      in_byte  = 8'h0D;
      @(negedge clk);
      in_byte  = 8'h0A;
      chk_out("R13 b2b CR", 1'b0, 8'h00, 3'd2, 3'd0, 3'd7);
      @(negedge clk);
      in_byte  = 8'h5A;
      chk_out("R13 b2b LF", 1'b0, 8'h00, 3'd3, 3'd0, 3'd7);
      @(negedge clk);
      in_valid = 1'b0;
      chk_out("R13 b2b char", 1'b1, 8'h5A, 3'd0, 3'd0, 3'd7);

      // R12: reset in the middle of a sequence returns to text mode
      in_valid = 1'b1;
      in_byte = 8'h1B; @(negedge clk);
      in_byte = 8'h5B; @(negedge clk);
      in_byte = 8'h33; @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b1;
      in_byte = 8'h33;
      @(negedge clk);
      in_valid = 1'b0;
      chk_out("R12 text after reset", 1'b1, 8'h33, 3'd0, 3'd0, 3'd7);

      // R9: ESC inside an open sequence aborts, the next byte prints
      in_valid = 1'b1;
      in_byte = 8'h1B; @(negedge clk);
      in_byte = 8'h5B; @(negedge clk);
      in_byte = 8'h1B; @(negedge clk);
      chk_out("R9 esc in seq", 1'b0, 8'h00, 3'd0, 3'd0, 3'd7);
      in_byte = 8'h5B; @(negedge clk);
      in_valid = 1'b0;
      chk_out("R9 after esc abort", 1'b1, 8'h5B, 3'd0, 3'd0, 3'd7);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule